// File: doc/BRIEF.md
# Flash byte-program sequencer

This controller drives the write side of a parallel flash memory that programs one byte at a time. The host raises a one-cycle request with an address and a data byte. The controller switches on the programming supply and waits for it to settle. It then runs a write cycle: the address and data go onto the bus, chip-enable drops, and write-enable is pulsed. After that it times the program pulse, which the memory stops on its own, and then the recovery interval. Last, it asks an external read path to return the byte now stored at that address.

If the returned byte differs from the requested byte, the write, program and recovery steps run again. The number of passes has an upper limit. When the byte matches, or when the last allowed pass fails, the controller gives a one-cycle completion pulse, a pass/fail flag and the number of passes it used.

Every interval is a nanosecond or microsecond parameter. It is turned into whole clock cycles by rounding up the ratio to the clock-period parameter, so the same code meets the strobe timing at any clock rate.

Top module: `fbp_sequencer`

## Requirements
- R1: Out of reset, and whenever no request is in progress, chip-enable and write-enable are high, and the supply enable, data-drive enable, verify request, busy and done outputs are all low.
- R2: An accepted request raises the supply enable in the next cycle. Chip-enable then falls exactly ceil(T_VPS_NS/CLK_PERIOD_NS) cycles after the supply enable rose, and it is never low while the supply enable is low.
- R3: Each write-enable low pulse lasts exactly N_WP = max(ceil(T_WP_NS/P), ceil(T_DS_NS/P)) cycles, where P is the clock period. Write-enable is low only while chip-enable is low and the data bus is driven.
- R4: Chip-enable stays low for exactly 1 + N_WP + N_HOLD cycles per write, where N_HOLD = max(ceil(T_DH_NS/P), ceil(T_AH_NS/P) − N_WP, ceil(T_WC_NS/P) − 1 − N_WP), with any negative term taken as zero. While chip-enable is low, the address and data outputs show the latched request unchanged and the drive enable is high. At all other times the drive enable is low.
- R5: The verify request rises exactly N_HOLD + N_PGM + N_WR cycles after write-enable rises. N_PGM = max(ceil(T_PGM_NS/P), ceil(T_WPH_NS/P)) and N_WR = ceil(T_WR_NS/P).
- R6: A verify result whose byte equals the requested byte in every bit completes the request: done rises for one cycle with error low, and the reported count equals the number of write pulses issued.
- R7: A verify result that differs in any single bit, before the pass limit is reached, starts another write cycle at the same address with the same data.
- R8: If the byte still fails verify on pass MAX_LOOPS, done is given with error high and a count of MAX_LOOPS, and no further write pulse follows.
- R9: Done is a single-cycle pulse. Busy is already low in that cycle, and error and the count keep their values until the next completion.
- R10: A request raised while busy is ignored. The latched address and data do not change, and no extra completion follows.
- R11: A verify-valid strobe outside the verify wait has no effect on timing, pass count or completion.
- R12: The verify request stays high until the cycle in which verify-valid is sampled high, and never while chip-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a byte program; taken only when idle |
| req_addr | input | ADDR_W | Target byte address |
| req_data | input | DATA_W | Byte to program |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last completion failed all passes |
| loops_used | output | LOOP_W | Passes used by the last completion |
| flash_addr | output | ADDR_W | Address bus to memory |
| flash_dout | output | DATA_W | Data bus to memory |
| flash_dout_en | output | 1 | Data bus drive enable |
| flash_ce_n | output | 1 | Chip-enable, active low |
| flash_we_n | output | 1 | Write-enable, active low |
| vpp_en | output | 1 | Programming supply enable |
| vfy_req | output | 1 | Request a read-back of the target byte |
| vfy_valid | input | 1 | Read-back byte is valid |
| vfy_data | input | DATA_W | Read-back byte |

## Verification
If one timing state runs too long or too short, the run lengths of the strobes at the pins change within the same write cycle. The gap from write-enable rising to the verify request moves by the same number of cycles, so a wrong limit in the shared interval timer shows up at the first pass. A pass counter that is off by one shows up at completion: the reported count differs from the number of write pulses counted at the pins, or an extra pulse appears after the last allowed pass. A latch that reloads while busy puts a wrong address on the bus during the next retry write.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_VPP  = 3'd1,
        ST_ASU  = 3'd2,
        ST_WEL  = 3'd3,
        ST_HOLD = 3'd4,
        ST_PGM  = 3'd5,
        ST_REC  = 3'd6,
        ST_VFY  = 3'd7
    } fbp_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic dout_en;
        logic vpp_en;
        logic vfy_req;
        logic busy;
    } fbp_strobe_t;

    function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned per_ns);
        int unsigned c;
        c = (t_ns + per_ns - 1) / per_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned sub_floor(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

    function automatic fbp_strobe_t strobes_for(input fbp_state_e st);
        fbp_strobe_t s;
        s.ce_n    = 1'b1;
        s.we_n    = 1'b1;
        s.dout_en = 1'b0;
        s.vpp_en  = (st != ST_IDLE);
        s.vfy_req = (st == ST_VFY);
        s.busy    = (st != ST_IDLE);
        if (st == ST_ASU || st == ST_WEL || st == ST_HOLD) begin
            s.ce_n    = 1'b0;
            s.dout_en = 1'b1;
        end
        if (st == ST_WEL) begin
            s.we_n = 1'b0;
        end
        return s;
    endfunction

endpackage

// File: rtl/fbp_interval_timer.sv
module fbp_interval_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        last = (({1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (!last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fbp_loop_counter.sv
module fbp_loop_counter #(
    parameter int unsigned MAX_LOOPS = 25,
    parameter int unsigned LOOP_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              inc,
    output logic [LOOP_W-1:0] count,
    output logic              at_max
);
    localparam logic [LOOP_W-1:0] LIMIT = LOOP_W'(MAX_LOOPS);
    logic [LOOP_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= LOOP_W'(1);
        end else if (inc && (count_q < LIMIT)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count  = count_q;
    assign at_max = (count_q >= LIMIT);
endmodule

// File: rtl/fbp_verify_cmp.sv
module fbp_verify_cmp #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] expected,
    input  logic [DATA_W-1:0] observed,
    output logic              match
);
    logic [DATA_W-1:0] diff;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign diff[b] = expected[b] ^ observed[b];
    end

    assign match = (diff == '0);
endmodule

// File: rtl/fbp_sequencer.sv
module fbp_sequencer
    import fbp_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned ADDR_W        = 17,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned MAX_LOOPS     = 25,
    parameter int unsigned T_VPS_NS      = 100,
    parameter int unsigned T_WP_NS       = 40,
    parameter int unsigned T_WPH_NS      = 20,
    parameter int unsigned T_WC_NS       = 70,
    parameter int unsigned T_DS_NS       = 40,
    parameter int unsigned T_DH_NS       = 10,
    parameter int unsigned T_AH_NS       = 40,
    parameter int unsigned T_PGM_NS      = 10000,
    parameter int unsigned T_WR_NS       = 6000,
    localparam int unsigned LOOP_W       = $clog2(MAX_LOOPS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [LOOP_W-1:0] loops_used,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [DATA_W-1:0] flash_dout,
    output logic              flash_dout_en,
    output logic              flash_ce_n,
    output logic              flash_we_n,
    output logic              vpp_en,
    output logic              vfy_req,
    input  logic              vfy_valid,
    input  logic [DATA_W-1:0] vfy_data
);
    // Interval lengths in clock cycles
    localparam int unsigned N_VPS  = ns_to_cyc(T_VPS_NS, CLK_PERIOD_NS);
    localparam int unsigned N_WP   = umax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                          ns_to_cyc(T_DS_NS, CLK_PERIOD_NS));
    localparam int unsigned N_HOLD = umax(ns_to_cyc(T_DH_NS, CLK_PERIOD_NS),
                                     umax(sub_floor(ns_to_cyc(T_AH_NS, CLK_PERIOD_NS), N_WP),
                                          sub_floor(ns_to_cyc(T_WC_NS, CLK_PERIOD_NS), 1 + N_WP)));
    localparam int unsigned N_PGM  = umax(ns_to_cyc(T_PGM_NS, CLK_PERIOD_NS),
                                          ns_to_cyc(T_WPH_NS, CLK_PERIOD_NS));
    localparam int unsigned N_WR   = ns_to_cyc(T_WR_NS, CLK_PERIOD_NS);
    localparam int unsigned N_MAX  = umax(umax(N_VPS, N_WP), umax(umax(N_HOLD, N_PGM), N_WR));
    localparam int unsigned CNT_W  = $clog2(N_MAX + 1);

    localparam logic [CNT_W-1:0] L_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] L_VPS  = CNT_W'(N_VPS);
    localparam logic [CNT_W-1:0] L_WP   = CNT_W'(N_WP);
    localparam logic [CNT_W-1:0] L_HOLD = CNT_W'(N_HOLD);
    localparam logic [CNT_W-1:0] L_PGM  = CNT_W'(N_PGM);
    localparam logic [CNT_W-1:0] L_WR   = CNT_W'(N_WR);

    fbp_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              done_q, error_q;
    logic [LOOP_W-1:0] loops_q;

    logic              t_last, t_restart;
    logic [CNT_W-1:0]  t_limit;
    logic              loop_clear, loop_inc, loop_at_max;
    logic [LOOP_W-1:0] loop_cnt;
    logic              vfy_match;
    logic              finish, finish_err;
    fbp_strobe_t       strb;

    fbp_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (t_restart),
        .limit   (t_limit),
        .last    (t_last)
    );

    fbp_loop_counter #(.MAX_LOOPS(MAX_LOOPS), .LOOP_W(LOOP_W)) u_loops (
        .clk    (clk),
        .rst    (rst),
        .clear  (loop_clear),
        .inc    (loop_inc),
        .count  (loop_cnt),
        .at_max (loop_at_max)
    );

    fbp_verify_cmp #(.DATA_W(DATA_W)) u_cmp (
        .expected (data_q),
        .observed (vfy_data),
        .match    (vfy_match)
    );

    // Interval length for the state now running
    always_comb begin
        unique case (state_q)
            ST_VPP:  t_limit = L_VPS;
            ST_WEL:  t_limit = L_WP;
            ST_HOLD: t_limit = L_HOLD;
            ST_PGM:  t_limit = L_PGM;
            ST_REC:  t_limit = L_WR;
            default: t_limit = L_ONE;
        endcase
    end

    always_comb begin
        state_d    = state_q;
        loop_clear = 1'b0;
        loop_inc   = 1'b0;
        finish     = 1'b0;
        finish_err = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d    = ST_VPP;
                    loop_clear = 1'b1;
                end
            end
            ST_VPP:  if (t_last) state_d = ST_ASU;
            ST_ASU:  if (t_last) state_d = ST_WEL;
            ST_WEL:  if (t_last) state_d = ST_HOLD;
            ST_HOLD: if (t_last) state_d = ST_PGM;
            ST_PGM:  if (t_last) state_d = ST_REC;
            ST_REC:  if (t_last) state_d = ST_VFY;
            ST_VFY: begin
                if (vfy_valid) begin
                    if (vfy_match) begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end else if (loop_at_max) begin
                        state_d    = ST_IDLE;
                        finish     = 1'b1;
                        finish_err = 1'b1;
                    end else begin
                        state_d  = ST_ASU;
                        loop_inc = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign t_restart = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            done_q  <= 1'b0;
            error_q <= 1'b0;
            loops_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req) begin
                addr_q <= req_addr;
                data_q <= req_data;
            end
            done_q <= finish;
            if (finish) begin
                error_q <= finish_err;
                loops_q <= loop_cnt;
            end
        end
    end

    assign strb          = strobes_for(state_q);
    assign busy          = strb.busy;
    assign flash_ce_n    = strb.ce_n;
    assign flash_we_n    = strb.we_n;
    assign flash_dout_en = strb.dout_en;
    assign vpp_en        = strb.vpp_en;
    assign vfy_req       = strb.vfy_req;
    assign flash_addr    = addr_q;
    assign flash_dout    = data_q;
    assign done          = done_q;
    assign error         = error_q;
    assign loops_used    = loops_q;
endmodule

// File: rtl/fbp_sequencer_chk.sv
module fbp_sequencer_chk #(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned MAX_LOOPS = 25,
    parameter int unsigned LOOP_W    = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic [LOOP_W-1:0] loops_used,
    input logic [ADDR_W-1:0] flash_addr,
    input logic [DATA_W-1:0] flash_dout,
    input logic              flash_dout_en,
    input logic              flash_ce_n,
    input logic              flash_we_n,
    input logic              vpp_en,
    input logic              vfy_req,
    input logic              vfy_valid
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (flash_ce_n && flash_we_n && !vpp_en && !flash_dout_en && !vfy_req));
    // R2
    ce_needs_vpp_chk: assert property (@(posedge clk) disable iff (rst)
        !flash_ce_n |-> vpp_en);
    // R3
    we_inside_ce_chk: assert property (@(posedge clk) disable iff (rst)
        !flash_we_n |-> (!flash_ce_n && flash_dout_en));
    // R4
    bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!flash_ce_n && !$past(flash_ce_n)) |-> ($stable(flash_addr) && $stable(flash_dout)));
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R8
    loops_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (loops_used >= LOOP_W'(1) && loops_used <= LOOP_W'(MAX_LOOPS)));
    // R8
    error_at_max_chk: assert property (@(posedge clk) disable iff (rst)
        (done && error) |-> (loops_used == LOOP_W'(MAX_LOOPS)));
    // R12
    vfy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (vfy_req && !vfy_valid) |=> vfy_req);
    // R12
    vfy_bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
        vfy_req |-> flash_ce_n);
endmodule

bind fbp_sequencer fbp_sequencer_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MAX_LOOPS (MAX_LOOPS),
    .LOOP_W    (LOOP_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .done          (done),
    .error         (error),
    .loops_used    (loops_used),
    .flash_addr    (flash_addr),
    .flash_dout    (flash_dout),
    .flash_dout_en (flash_dout_en),
    .flash_ce_n    (flash_ce_n),
    .flash_we_n    (flash_we_n),
    .vpp_en        (vpp_en),
    .vfy_req       (vfy_req),
    .vfy_valid     (vfy_valid)
);

// File: tb/fbp_sequencer_bench.sv
module fbp_sequencer_bench;
    localparam int CLK_NS  = 10;
    localparam int PGM_NS  = 300;
    localparam int WR_NS   = 200;
    localparam int MAXL    = 25;
    localparam int WD_CYC  = 150000;

    function automatic int cdiv(input int t, input int p);
        int c;
        c = (t + p - 1) / p;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_VPS  = cdiv(100, CLK_NS);
    localparam int E_WP   = imax(cdiv(40, CLK_NS), cdiv(40, CLK_NS));
    localparam int E_HOLD = imax(cdiv(10, CLK_NS), imax(cdiv(40, CLK_NS) - E_WP, cdiv(70, CLK_NS) - 1 - E_WP));
    localparam int E_PGM  = imax(cdiv(PGM_NS, CLK_NS), cdiv(20, CLK_NS));
    localparam int E_WR   = cdiv(WR_NS, CLK_NS);
    localparam int E_CE   = 1 + E_WP + E_HOLD;
    localparam int E_GAP  = E_HOLD + E_PGM + E_WR;

    typedef struct packed {
        logic [16:0] addr;
        logic [7:0]  data;
        logic [7:0]  mask;
        logic [5:0]  pass;
        logic [3:0]  dly;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{17'h00000, 8'h5A, 8'h01, 6'd1,  4'd0},
        '{17'h1FFFF, 8'hA5, 8'h80, 6'd3,  4'd2},
        '{17'h0AAAA, 8'h00, 8'hFF, 6'd25, 4'd1},
        '{17'h15555, 8'hFF, 8'h10, 6'd0,  4'd0},
        '{17'h00F0F, 8'h3C, 8'h40, 6'd2,  4'd5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        busy, done, error;
    logic [4:0]  loops_used;
    logic [16:0] flash_addr;
    logic [7:0]  flash_dout;
    logic        flash_dout_en, flash_ce_n, flash_we_n, vpp_en, vfy_req;
    logic        vfy_valid;
    logic [7:0]  vfy_data;

    logic        resp_v = 1'b0, spur_v = 1'b0;
    logic [7:0]  resp_d = '0, spur_d = '0;
    assign vfy_valid = resp_v | spur_v;
    assign vfy_data  = spur_v ? spur_d : resp_d;

    fbp_sequencer #(
        .CLK_PERIOD_NS (CLK_NS),
        .MAX_LOOPS     (MAXL),
        .T_PGM_NS      (PGM_NS),
        .T_WR_NS       (WR_NS)
    ) u_fbp_sequencer (
        .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .req_data(req_data),
        .busy(busy), .done(done), .error(error), .loops_used(loops_used),
        .flash_addr(flash_addr), .flash_dout(flash_dout), .flash_dout_en(flash_dout_en),
        .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n), .vpp_en(vpp_en),
        .vfy_req(vfy_req), .vfy_valid(vfy_valid), .vfy_data(vfy_data)
    );

    always #(CLK_NS / 2) clk = ~clk;

    int n_tests = 0, n_fail = 0;

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Transaction context and pin statistics
    logic [16:0] t_addr = '0;
    logic [7:0]  t_data = '0, t_mask = '0;
    int t_pass = 0, t_delay = 0;
    int cyc = 0, resp_wait = 0;
    logic p_vpp = 0, p_ce_n = 1, p_we_n = 1, p_vfy = 0, first_ce = 1;
    int vpp_rise = 0, we_rise = 0, we_run = 0, ce_run = 0, vfy_run = 0;
    int st_vpp2ce, st_we_min, st_we_max, st_ce_min, st_ce_max, st_gap_min, st_gap_max;
    int st_vfy_min, st_vfy_max, st_pulses, st_bus_bad, st_done_cnt, st_done_busy, st_loops;
    logic st_err;

    task automatic clear_stats();
        st_vpp2ce = -1; first_ce = 1'b1;
        st_we_min = 1000000; st_we_max = -1;
        st_ce_min = 1000000; st_ce_max = -1;
        st_gap_min = 1000000; st_gap_max = -1;
        st_vfy_min = 1000000; st_vfy_max = -1;
        st_pulses = 0; st_bus_bad = 0; st_done_cnt = 0; st_done_busy = 0;
        st_loops = -1; st_err = 1'b0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            resp_v = 0; resp_wait = 0; p_vpp = 0; p_ce_n = 1; p_we_n = 1; p_vfy = 0;
            we_run = 0; ce_run = 0; vfy_run = 0;
        end else begin
            if (vpp_en && !p_vpp) vpp_rise = cyc;
            if (!flash_ce_n && p_ce_n && first_ce) begin
                st_vpp2ce = cyc - vpp_rise; first_ce = 0;
            end
            if (!flash_we_n) we_run++;
            if (flash_we_n && !p_we_n) begin
                if (we_run < st_we_min) st_we_min = we_run;
                if (we_run > st_we_max) st_we_max = we_run;
                st_pulses++; we_rise = cyc; we_run = 0;
            end
            if (!flash_ce_n) begin
                ce_run++;
                if (flash_addr !== t_addr || flash_dout !== t_data || flash_dout_en !== 1'b1) st_bus_bad++;
            end else if (flash_dout_en) begin
                st_bus_bad++;
            end
            if (flash_ce_n && !p_ce_n) begin
                if (ce_run < st_ce_min) st_ce_min = ce_run;
                if (ce_run > st_ce_max) st_ce_max = ce_run;
                ce_run = 0;
            end
            if (vfy_req && !p_vfy) begin
                if (cyc - we_rise < st_gap_min) st_gap_min = cyc - we_rise;
                if (cyc - we_rise > st_gap_max) st_gap_max = cyc - we_rise;
            end
            if (vfy_req) vfy_run++;
            else if (p_vfy) begin
                if (vfy_run < st_vfy_min) st_vfy_min = vfy_run;
                if (vfy_run > st_vfy_max) st_vfy_max = vfy_run;
                vfy_run = 0;
            end
            if (done) begin
                st_done_cnt++; st_err = error; st_loops = int'(loops_used);
                if (busy) st_done_busy++;
            end
            // read-back responder
            if (resp_v) begin
                resp_v = 0; resp_wait = 0;
            end else if (vfy_req) begin
                if (resp_wait >= t_delay) begin
                    resp_v = 1;
                    resp_d = (t_pass != 0 && st_pulses >= t_pass) ? t_data : (t_data ^ t_mask);
                end else begin
                    resp_wait++;
                end
            end
            p_vpp = vpp_en; p_ce_n = flash_ce_n; p_we_n = flash_we_n; p_vfy = vfy_req;
        end
    end

    task automatic start_txn(input logic [16:0] a, input logic [7:0] d, input int pass,
                             input logic [7:0] m, input int dly);
        t_addr = a; t_data = d; t_pass = pass; t_mask = m; t_delay = dly;
        clear_stats();
        @(posedge clk); #1;
        req = 1'b1; req_addr = a; req_data = d;
        @(posedge clk); #1;
        req = 1'b0; req_addr = ~a; req_data = ~d;
    endtask

    task automatic finish_txn(input int pass, input int dly);
        int exp_loops;
        bit exp_err;
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk); #1;
            if (st_done_cnt > 0) break;
        end
        repeat (40) @(posedge clk);
        #1;
        exp_err   = (pass == 0 || pass > MAXL);
        exp_loops = exp_err ? MAXL : pass;
        chk("R2", "supply-to-chip-enable cycles", st_vpp2ce, E_VPS);
        chk("R3", "write pulse min width", st_we_min, E_WP);
        chk("R3", "write pulse max width", st_we_max, E_WP);
        chk("R4", "chip-enable low min", st_ce_min, E_CE);
        chk("R4", "chip-enable low max", st_ce_max, E_CE);
        chk("R4", "bus hold violations", st_bus_bad, 0);
        chk("R5", "write-rise to verify min", st_gap_min, E_GAP);
        chk("R5", "write-rise to verify max", st_gap_max, E_GAP);
        chk("R12", "verify request length", st_vfy_max, dly + 1);
        chk("R12", "verify request length min", st_vfy_min, dly + 1);
        chk(exp_err ? "R8" : "R6", "error flag", st_err, exp_err);
        chk(exp_err ? "R8" : "R7", "reported passes", st_loops, exp_loops);
        chk(exp_err ? "R8" : "R7", "write pulses", st_pulses, exp_loops);
        chk("R9", "done cycles", st_done_cnt, 1);
        chk("R9", "busy during done", st_done_busy, 0);
        chk("R9", "error held after done", error, exp_err);
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R9 watchdog expired: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        clear_stats();
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ce_n after reset", flash_ce_n, 1);
        chk("R1", "we_n after reset", flash_we_n, 1);
        chk("R1", "vpp_en after reset", vpp_en, 0);
        chk("R1", "busy/done/vfy_req after reset", {busy, done, vfy_req, flash_dout_en}, 0);

        // Table of vectors
        for (int v = 0; v < 5; v++) begin
            start_txn(VECS[v].addr, VECS[v].data, int'(VECS[v].pass), VECS[v].mask, int'(VECS[v].dly));
            finish_txn(int'(VECS[v].pass), int'(VECS[v].dly));
        end

        // R10: request while busy is ignored
        fork
            begin
                start_txn(17'h12345, 8'hC3, 2, 8'h02, 1);
                finish_txn(2, 1);
            end
            begin
                repeat (25) @(posedge clk);
                #1;
                req = 1'b1; req_addr = 17'h00001; req_data = 8'h11;
                @(posedge clk); #1;
                req = 1'b0;
            end
        join
        chk("R10", "idle after ignored request", busy, 0);

        // R11: stray verify-valid while idle
        clear_stats();
        @(posedge clk); #1;
        spur_v = 1'b1; spur_d = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        spur_v = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "done from stray strobe while idle", st_done_cnt, 0);
        chk("R11", "busy from stray strobe while idle", busy, 0);

        // R11: stray verify-valid during program wait
        fork
            begin
                start_txn(17'h0BEEF, 8'h96, 1, 8'h04, 0);
                finish_txn(1, 0);
            end
            begin
                repeat (22) @(posedge clk);
                #1;
                spur_v = 1'b1; spur_d = 8'h96;
                repeat (5) @(posedge clk);
                #1;
                spur_v = 1'b0;
            end
        join
        chk("R11", "busy after stray strobe run", busy, 0);

        // R1: reset in the middle of a write pulse
        clear_stats();
        t_addr = 17'h00777; t_data = 8'h77; t_pass = 1; t_delay = 0;
        @(posedge clk); #1;
        req = 1'b1; req_addr = 17'h00777; req_data = 8'h77;
        @(posedge clk); #1;
        req = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            if (!flash_we_n) break;
        end
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "ce_n in reset mid-write", flash_ce_n, 1);
        chk("R1", "we_n in reset mid-write", flash_we_n, 1);
        chk("R1", "vpp/busy in reset mid-write", {vpp_en, busy}, 0);
        rst = 1'b0;
        start_txn(17'h1C0DE, 8'hE1, 1, 8'h08, 3);
        finish_txn(1, 3);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule